// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control state of a single root-hub port in a USB host controller and presents it as one 32-bit register word. It tracks whether a device is attached, whether the port is enabled, over-current, reset activity, port power, link power state, the speed of the attached device, the indicator colour and the wake enables. Seven change flags record events until software acknowledges them by writing ones.

A simple port model drives the inputs. It supplies the attach level, the over-current level, link-state reports, the detected speed and a reset-finished pulse. Software writes the register through a single write port. The block returns the register image, a reset request and a warm-reset request to the port model, and a one-cycle change pulse to the controller's status logic. Every output comes straight from a flip-flop, so every result is due on the clock edge after its cause.

Top module: `port_status_reg`

## Requirements
- R1: After reset the register reads 32'h0000_0200, with only port power (bit 9) set. reset_req, warm_req and change_pulse are 0.
- R2: Bits 2, 16, 24, 28, 29, 30 and 31 always read 0.
- R3: Bit 0 shows port_connect one clock after it is sampled. Connect change (bit 17) sets on every change of that level.
- R4: Bit 3 shows port_overcurrent one clock later. Over-current change (bit 20) sets on every change of that level.
- R5: A write with bit 4 set, while bit 0 and bit 9 read 1 and no reset is running, sets bit 4 and reset_req. In any other state the write is ignored.
- R6: A reset_done pulse while bit 4 is 1 does four things: it clears bit 4, sets bit 1, loads speed_in into bits 13:10 and sets reset change (bit 21). Speed codes are 0 undefined, 1 full, 2 low, 3 high and 4 SuperSpeed. The pulse is ignored when no reset is running.
- R7: A write with bit 31 set, under the conditions of R5, starts a warm reset. It raises bit 4 and warm_req. On completion it sets warm-reset change (bit 19) together with bit 21.
- R8: Loss of connection clears bit 1 and bits 13:10. If the port was enabled, it sets enable change (bit 18). If a reset was running, it aborts the reset and clears reset_req without setting bit 21. Writing 1 to bit 1 disables the port without setting bit 18.
- R9: Link state (bits 8:5) takes the written value only when bit 16 is 1 in the same write. In that case it takes priority over a link_evt report in the same cycle. Otherwise a link_evt pulse loads link_state_in.
- R10: Link change (bit 22) sets when a link_evt report moves the state in one of these ways: 3 (U3) to 15 (resume); 15, 2 (U2), 3 or 8 (recovery) to 0 (U0); or any other state to 6 (inactive). Software writes never set it.
- R11: Change bits 23:17 clear only where a write carries a 1. An event in the same cycle as its clear leaves the bit set.
- R12: change_pulse is high for exactly the cycle in which one or more change flags go from 0 to 1. It does not pulse for an event whose flag is already set.
- R13: Indicator bits 15:14 store written codes 0 (off), 1 (amber) and 2 (green). A write of code 3 leaves them unchanged. Power (bit 9) and the wake enables for connect, disconnect and over-current (bits 25 to 27) store whatever is written.
- R14: A config_error pulse sets configure-error change (bit 23).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| port_connect | input | 1 | Device attached level from the port model |
| port_overcurrent | input | 1 | Over-current level from the port model |
| link_evt | input | 1 | Port model reports a new link state |
| link_state_in | input | 4 | Reported link state |
| speed_in | input | 4 | Detected device speed code |
| reset_done | input | 1 | Port model finished the requested reset |
| config_error | input | 1 | Port failed to configure its link partner |
| reg_value | output | 32 | Register image |
| reset_req | output | 1 | Port reset in progress request |
| warm_req | output | 1 | Warm reset in progress request |
| change_pulse | output | 1 | One-cycle pulse on a newly set change flag |

## Verification
Every register field, each request output and the change pulse update on the first rising edge after the input or write that causes them, so each result is due exactly one clock later. The bench changes inputs on the falling edge, holds each pulse for one cycle and reads results on the next falling edge. At that point the edge in between has applied the stimulus and nothing has been applied after it. A behavioural model advances on the same rising edge and is compared with all outputs at every falling edge. The directed checks target the one cycle in which each flag, request or pulse first appears.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int REG_W   = 32;
  localparam int LS_W    = 4;
  localparam int SPD_W   = 4;
  localparam int NCHG    = 7;

  localparam int B_CONN  = 0;
  localparam int B_EN    = 1;
  localparam int B_OC    = 3;
  localparam int B_RST   = 4;
  localparam int B_LS    = 5;
  localparam int B_PWR   = 9;
  localparam int B_SPD   = 10;
  localparam int B_IND   = 14;
  localparam int B_LSTB  = 16;
  localparam int B_CHG   = 17;
  localparam int B_WAKE  = 25;
  localparam int B_WARM  = 31;

  typedef enum int {
    CH_CONN = 0, CH_EN = 1, CH_WARM = 2, CH_OC = 3,
    CH_RST = 4, CH_LINK = 5, CH_CFG = 6
  } chg_idx_e;

  localparam logic [LS_W-1:0] LS_U0    = 4'd0;
  localparam logic [LS_W-1:0] LS_U2    = 4'd2;
  localparam logic [LS_W-1:0] LS_U3    = 4'd3;
  localparam logic [LS_W-1:0] LS_INACT = 4'd6;
  localparam logic [LS_W-1:0] LS_RECOV = 4'd8;
  localparam logic [LS_W-1:0] LS_RESUM = 4'd15;

  function automatic logic link_move_flags(input logic [LS_W-1:0] prev,
                                           input logic [LS_W-1:0] next);
    logic hit;
    hit = 1'b0;
    if (next == LS_INACT && prev != LS_INACT) hit = 1'b1;
    if (prev == LS_U3 && next == LS_RESUM) hit = 1'b1;
    if (next == LS_U0 && (prev == LS_RESUM || prev == LS_U2 ||
                          prev == LS_U3 || prev == LS_RECOV)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/psc_change_flags.sv
module psc_change_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags,
  output logic         pulse
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;
  logic [N-1:0] newly;
  logic         pulse_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flags_d[i] = set_vec[i] | (flags_q[i] & ~clr_vec[i]);
      newly[i]   = flags_d[i] & ~flags_q[i];
    end
    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= |newly;
  end

  assign flags = flags_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/psc_link_state.sv
module psc_link_state
  import psc_pkg::*;
#(
  parameter int W = LS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_val,
  input  logic         hw_evt,
  input  logic [W-1:0] hw_val,
  output logic [W-1:0] state,
  output logic         change_set
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst)         state_q <= LS_U0;
    else if (sw_wr)  state_q <= sw_val;
    else if (hw_evt) state_q <= hw_val;
  end

  always_comb begin
    change_set = hw_evt & ~sw_wr & link_move_flags(state_q, hw_val);
  end

  assign state = state_q;
endmodule

// File: rtl/psc_reset_ctrl.sv
module psc_reset_ctrl #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          attached,
  input  logic          powered,
  input  logic          detach_evt,
  input  logic          start_hot,
  input  logic          start_warm,
  input  logic          sw_disable,
  input  logic          done,
  input  logic [SW-1:0] speed_in,
  output logic          in_reset,
  output logic          in_warm,
  output logic          enabled,
  output logic [SW-1:0] speed,
  output logic          en_change_set,
  output logic          rst_change_set,
  output logic          warm_change_set
);
  logic          pr_q, wpr_q, ped_q;
  logic [SW-1:0] spd_q;
  logic          pr_d, wpr_d, ped_d;
  logic [SW-1:0] spd_d;
  logic          may_start;

  always_comb begin
    pr_d            = pr_q;
    wpr_d           = wpr_q;
    ped_d           = ped_q;
    spd_d           = spd_q;
    en_change_set   = 1'b0;
    rst_change_set  = 1'b0;
    warm_change_set = 1'b0;
    may_start       = attached & powered & ~pr_q;
    if (detach_evt) begin
      pr_d          = 1'b0;
      wpr_d         = 1'b0;
      ped_d         = 1'b0;
      spd_d         = '0;
      en_change_set = ped_q;
    end else if (pr_q && done) begin
      pr_d            = 1'b0;
      wpr_d           = 1'b0;
      ped_d           = 1'b1;
      spd_d           = speed_in;
      rst_change_set  = 1'b1;
      warm_change_set = wpr_q;
    end else if (may_start && (start_hot || start_warm)) begin
      pr_d  = 1'b1;
      wpr_d = start_warm;
      ped_d = 1'b0;
    end else if (sw_disable) begin
      ped_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_q  <= 1'b0;
      wpr_q <= 1'b0;
      ped_q <= 1'b0;
      spd_q <= '0;
    end else begin
      pr_q  <= pr_d;
      wpr_q <= wpr_d;
      ped_q <= ped_d;
      spd_q <= spd_d;
    end
  end

  assign in_reset = pr_q;
  assign in_warm  = wpr_q;
  assign enabled  = ped_q;
  assign speed    = spd_q;
endmodule

// File: rtl/port_status_reg.sv
module port_status_reg
  import psc_pkg::*;
#(
  parameter logic PP_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              port_connect,
  input  logic              port_overcurrent,
  input  logic              link_evt,
  input  logic [LS_W-1:0]   link_state_in,
  input  logic [SPD_W-1:0]  speed_in,
  input  logic              reset_done,
  input  logic              config_error,
  output logic [REG_W-1:0]  reg_value,
  output logic              reset_req,
  output logic              warm_req,
  output logic              change_pulse
);
  localparam int IND_W  = 2;
  localparam int WAKE_W = 3;
  localparam logic [IND_W-1:0] IND_BAD = 2'b11;

  logic                ccs_q, oca_q, pp_q;
  logic [IND_W-1:0]    pic_q;
  logic [WAKE_W-1:0]   wake_q;
  logic [LS_W-1:0]     pls;
  logic                plc_set;
  logic                pr, wpr, ped;
  logic [SPD_W-1:0]    spd;
  logic                pec_set, prc_set, wrc_set;
  logic [NCHG-1:0]     chg_set, chg_clr, chg;
  logic                detach_evt;
  logic                pulse;

  assign detach_evt = ccs_q & ~port_connect;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccs_q  <= 1'b0;
      oca_q  <= 1'b0;
      pp_q   <= PP_RESET;
      pic_q  <= '0;
      wake_q <= '0;
    end else begin
      ccs_q <= port_connect;
      oca_q <= port_overcurrent;
      if (wr_en) begin
        pp_q   <= wr_data[B_PWR];
        wake_q <= wr_data[B_WAKE +: WAKE_W];
        if (wr_data[B_IND +: IND_W] != IND_BAD)
          pic_q <= wr_data[B_IND +: IND_W];
      end
    end
  end

  psc_reset_ctrl #(.SW(SPD_W)) u_rst (
    .clk            (clk),
    .rst            (rst),
    .attached       (ccs_q),
    .powered        (pp_q),
    .detach_evt     (detach_evt),
    .start_hot      (wr_en & wr_data[B_RST]),
    .start_warm     (wr_en & wr_data[B_WARM]),
    .sw_disable     (wr_en & wr_data[B_EN]),
    .done           (reset_done),
    .speed_in       (speed_in),
    .in_reset       (pr),
    .in_warm        (wpr),
    .enabled        (ped),
    .speed          (spd),
    .en_change_set  (pec_set),
    .rst_change_set (prc_set),
    .warm_change_set(wrc_set)
  );

  psc_link_state #(.W(LS_W)) u_link (
    .clk       (clk),
    .rst       (rst),
    .sw_wr     (wr_en & wr_data[B_LSTB]),
    .sw_val    (wr_data[B_LS +: LS_W]),
    .hw_evt    (link_evt),
    .hw_val    (link_state_in),
    .state     (pls),
    .change_set(plc_set)
  );

  always_comb begin
    chg_set          = '0;
    chg_set[CH_CONN] = ccs_q ^ port_connect;
    chg_set[CH_EN]   = pec_set;
    chg_set[CH_WARM] = wrc_set;
    chg_set[CH_OC]   = oca_q ^ port_overcurrent;
    chg_set[CH_RST]  = prc_set;
    chg_set[CH_LINK] = plc_set;
    chg_set[CH_CFG]  = config_error;
    chg_clr          = wr_en ? wr_data[B_CHG +: NCHG] : '0;
  end

  psc_change_flags #(.N(NCHG)) u_chg (
    .clk    (clk),
    .rst    (rst),
    .set_vec(chg_set),
    .clr_vec(chg_clr),
    .flags  (chg),
    .pulse  (pulse)
  );

  always_comb begin
    reg_value                     = '0;
    reg_value[B_CONN]             = ccs_q;
    reg_value[B_EN]               = ped;
    reg_value[B_OC]               = oca_q;
    reg_value[B_RST]              = pr;
    reg_value[B_LS +: LS_W]       = pls;
    reg_value[B_PWR]              = pp_q;
    reg_value[B_SPD +: SPD_W]     = spd;
    reg_value[B_IND +: IND_W]     = pic_q;
    reg_value[B_CHG +: NCHG]      = chg;
    reg_value[B_WAKE +: WAKE_W]   = wake_q;
  end

  assign reset_req    = pr;
  assign warm_req     = wpr;
  assign change_pulse = pulse;
endmodule

// File: rtl/psc_checker.sv
module psc_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        link_evt,
  input logic [31:0] reg_value,
  input logic        reset_req,
  input logic        warm_req,
  input logic        change_pulse
);
  a_r6_prc_on_pr_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_value[21]) |-> $fell(reg_value[4]));

  a_r7_wrc_after_warm: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_value[19]) |-> $past(warm_req));

  a_r8_speed_cleared_detached: assert property (@(posedge clk) disable iff (rst)
    !reg_value[0] |-> (reg_value[13:10] == 4'd0));

  a_r9_ls_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[16] && !link_evt) |=> $stable(reg_value[8:5]));

  a_r11_w1c_only: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((reg_value[23:17] & $past(reg_value[23:17])) == $past(reg_value[23:17])));

  a_r12_pulse_has_flag: assert property (@(posedge clk) disable iff (rst)
    change_pulse |-> (reg_value[23:17] != 7'd0));

  a_r13_ind_code3_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[15:14] == 2'b11) |=> $stable(reg_value[15:14]));

  a_r5_req_needs_attach: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> $past(reg_value[0]));
endmodule

bind port_status_reg psc_checker u_psc_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .link_evt    (link_evt),
  .reg_value   (reg_value),
  .reset_req   (reset_req),
  .warm_req    (warm_req),
  .change_pulse(change_pulse)
);

// File: tb/tb_port_status_reg.sv
`timescale 1ns/1ps
module tb_port_status_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        port_connect = 1'b0;
  logic        port_overcurrent = 1'b0;
  logic        link_evt = 1'b0;
  logic [3:0]  link_state_in = '0;
  logic [3:0]  speed_in = '0;
  logic        reset_done = 1'b0;
  logic        config_error = 1'b0;
  logic [31:0] reg_value;
  logic        reset_req, warm_req, change_pulse;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  port_status_reg dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .port_connect(port_connect), .port_overcurrent(port_overcurrent),
    .link_evt(link_evt), .link_state_in(link_state_in), .speed_in(speed_in),
    .reset_done(reset_done), .config_error(config_error),
    .reg_value(reg_value), .reset_req(reset_req), .warm_req(warm_req),
    .change_pulse(change_pulse)
  );

  // behavioural reference
  bit       m_conn, m_oc, m_pwr, m_rst, m_warm, m_en, m_pulse;
  int       m_spd, m_ls, m_ind, m_wake;
  bit [6:0] m_chg;

  function automatic bit link_flag(int a, int b);
    if (b == 6) return a != 6;
    if (a == 3 && b == 15) return 1;
    if (b == 0) return (a == 15 || a == 2 || a == 3 || a == 8);
    return 0;
  endfunction

  always @(posedge clk) begin
    bit [6:0] s;
    bit w;
    s = '0;
    w = wr_en;
    if (rst) begin
      m_conn = 0; m_oc = 0; m_pwr = 1; m_rst = 0; m_warm = 0; m_en = 0;
      m_spd = 0; m_ls = 0; m_ind = 0; m_wake = 0; m_chg = '0; m_pulse = 0;
    end else begin
      if (m_conn != port_connect) s[0] = 1;
      if (m_oc != port_overcurrent) s[3] = 1;
      if (config_error) s[6] = 1;
      if (m_conn && !port_connect) begin
        if (m_en) s[1] = 1;
        m_rst = 0; m_warm = 0; m_en = 0; m_spd = 0;
      end else if (m_rst && reset_done) begin
        s[4] = 1;
        if (m_warm) s[2] = 1;
        m_rst = 0; m_warm = 0; m_en = 1; m_spd = speed_in;
      end else if (w && (wr_data[4] || wr_data[31]) && m_conn && m_pwr && !m_rst) begin
        m_rst = 1; m_warm = wr_data[31]; m_en = 0;
      end else if (w && wr_data[1]) begin
        m_en = 0;
      end
      if (w && wr_data[16]) m_ls = wr_data[8:5];
      else if (link_evt) begin
        if (link_flag(m_ls, link_state_in)) s[5] = 1;
        m_ls = link_state_in;
      end
      if (w) begin
        m_pwr = wr_data[9];
        m_wake = wr_data[27:25];
        if (wr_data[15:14] != 2'b11) m_ind = wr_data[15:14];
      end
      m_pulse = (s & ~m_chg) != 0;
      if (w) m_chg = m_chg & ~wr_data[23:17];
      m_chg = m_chg | s;
      m_conn = port_connect;
      m_oc = port_overcurrent;
    end
  end

  function automatic bit [31:0] model_word();
    bit [31:0] v;
    v = '0;
    v[0] = m_conn; v[1] = m_en; v[3] = m_oc; v[4] = m_rst;
    v[8:5] = m_ls[3:0]; v[9] = m_pwr; v[13:10] = m_spd[3:0];
    v[15:14] = m_ind[1:0]; v[23:17] = m_chg; v[27:25] = m_wake[2:0];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 register image vs model", reg_value, model_word());
      chk("R5 reset_req vs model", {31'd0, reset_req}, {31'd0, m_rst});
      chk("R7 warm_req vs model", {31'd0, warm_req}, {31'd0, m_warm});
      chk("R12 change_pulse vs model", {31'd0, change_pulse}, {31'd0, m_pulse});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [31:0] PW = 32'h200;

  task automatic step();
    @(negedge clk);
    wr_en = 0; link_evt = 0; reset_done = 0; config_error = 0;
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    chk("R1 reset image", reg_value, 32'h0000_0200);
    chk("R1 outputs idle", {29'd0, reset_req, warm_req, change_pulse}, 32'd0);

    wr(PW | 32'h10);
    chk("R5 reset ignored while detached", {31'd0, reg_value[4]}, 32'd0);

    port_connect = 1; step();
    chk("R3 connect bit", {31'd0, reg_value[0]}, 32'd1);
    chk("R3 connect change", {31'd0, reg_value[17]}, 32'd1);
    chk("R12 pulse on new flag", {31'd0, change_pulse}, 32'd1);
    step();
    chk("R12 pulse one cycle", {31'd0, change_pulse}, 32'd0);
    wr(PW);
    chk("R11 write 0 keeps flag", {31'd0, reg_value[17]}, 32'd1);
    wr(PW | (32'd1 << 17));
    chk("R11 write 1 clears flag", {31'd0, reg_value[17]}, 32'd0);

    wr(PW | 32'h10);
    chk("R5 reset started", {30'd0, reg_value[4], reset_req}, 32'd3);
    speed_in = 4'd3; reset_done = 1; step();
    chk("R6 reset finished", reg_value & 32'h0020_3C12, 32'h0020_0C02);
    wr(PW | (32'd1 << 21));
    reset_done = 1; step();
    chk("R6 stray done ignored", {31'd0, reg_value[21]}, 32'd0);

    wr(PW | 32'h2);
    chk("R8 sw disable no enable change", {30'd0, reg_value[18], reg_value[1]}, 32'd0);

    wr(PW | (32'd3 << 5));
    chk("R9 no strobe no update", {28'd0, reg_value[8:5]}, 32'd0);
    wr(PW | (32'd3 << 5) | (32'd1 << 16));
    chk("R9 strobed update", {28'd0, reg_value[8:5]}, 32'd3);
    chk("R10 sw write sets no link change", {31'd0, reg_value[22]}, 32'd0);
    link_evt = 1; link_state_in = 4'd15; step();
    chk("R10 U3 to resume", {31'd0, reg_value[22]}, 32'd1);
    link_evt = 1; link_state_in = 4'd0; step();
    chk("R12 no pulse when already set", {31'd0, change_pulse}, 32'd0);
    wr(PW | (32'd1 << 22));
    link_evt = 1; link_state_in = 4'd5; step();
    chk("R10 U0 to 5 no change", {31'd0, reg_value[22]}, 32'd0);
    link_evt = 1; link_state_in = 4'd6; step();
    chk("R10 to inactive", {31'd0, reg_value[22]}, 32'd1);
    link_evt = 1; link_state_in = 4'd2;
    wr(PW | (32'd9 << 5) | (32'd1 << 16) | (32'd1 << 22));
    chk("R9 strobe beats link report", {28'd0, reg_value[8:5]}, 32'd9);

    wr(PW | (32'd2 << 14) | (32'd5 << 25));
    chk("R13 indicator green", {30'd0, reg_value[15:14]}, 32'd2);
    chk("R13 wake enables", {29'd0, reg_value[27:25]}, 32'd5);
    wr(PW | (32'd3 << 14));
    chk("R13 code 3 ignored", {30'd0, reg_value[15:14]}, 32'd2);

    port_overcurrent = 1; step();
    chk("R4 over-current", {30'd0, reg_value[20], reg_value[3]}, 32'd3);
    port_overcurrent = 0; wr(PW | (32'd1 << 20));
    chk("R4 change on release", {30'd0, reg_value[20], reg_value[3]}, 32'd2);

    wr(PW | (32'd1 << 31));
    chk("R7 warm started", {29'd0, reg_value[4], reset_req, warm_req}, 32'd7);
    chk("R2 bit31 reads zero", {31'd0, reg_value[31]}, 32'd0);
    speed_in = 4'd4; reset_done = 1; step();
    chk("R7 warm finished", reg_value & 32'h0028_3C12, 32'h0028_1002);

    port_connect = 0; step();
    chk("R8 detach", reg_value & 32'h0004_3C03, 32'h0004_0000);

    wr(PW | (32'h7F << 17));
    port_connect = 1; step();
    wr(PW | 32'h10 | (32'd1 << 17));
    port_connect = 0; step();
    chk("R8 reset aborted", {29'd0, reg_value[21], reg_value[4], reset_req}, 32'd0);

    config_error = 1; step();
    chk("R14 config error", {31'd0, reg_value[23]}, 32'd1);
    config_error = 1; wr(PW | (32'd1 << 23));
    chk("R11 set beats clear", {31'd0, reg_value[23]}, 32'd1);

    wr(32'd0);
    chk("R13 power written off", {31'd0, reg_value[9]}, 32'd0);
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule